// File: doc/BRIEF.md
# Bus I/O Window Select Decoder

This block decodes the address of a 6502-style bus in two stages. The host-side stage looks at the upper address bits. It drives a shared active-low I/O select whenever the address lies inside a 2 KB I/O window, and a 2-bit personality code chooses where that window sits in the 64 KB map. One personality puts it at $E800, and the others move it elsewhere. The select is decoded address information only and is never used as a timing reference.

The board-side stage stands for one peripheral card. The card looks only at the low eleven address bits and the shared select. It matches bits 10..4 against a jumper-set board number, which claims a 16-byte register block, and it passes bits 3..0 on as the register index. Read and write strobes are formed from Phi2 and the read/write line, where high means read. A second strobe mode models buses that have separate read and write lines. In that mode each strobe is ORed with the shared select and the board match is bypassed.

Every output is combinational in the inputs. There is no state and no clock.

Top module: `io_sel_top`

## Requirements
- R1: `io_sel_no` is low exactly when `addr_i[15:11]` equals the window block picked by `pers_i`. The blocks are: code 0 → 5'h1D ($E800–$EFFF), code 1 → 5'h12 ($9000–$97FF), code 2 → 5'h18 ($C000–$C7FF), code 3 → 5'h1B ($D800–$DFFF).
- R2: `io_sel_no` follows `addr_i` and `pers_i` in the same time step with no register, and it does not depend on `phi2_i` or `rw_i`.
- R3: `board_cs_no` is low exactly when `io_sel_no` is low and `addr_i[10:4]` equals `board_id_i`.
- R4: `reg_idx_o` always equals `addr_i[3:0]`.
- R5: With `strobe_or_i`=0, `rd_no` is low exactly when `board_cs_no` is low, `rw_i`=1 and `phi2_i`=1.
- R6: With `strobe_or_i`=0, `wr_no` is low exactly when `board_cs_no` is low, `rw_i`=0 and `phi2_i`=1.
- R7: While `phi2_i` is low, `rd_no` and `wr_no` are both high in either mode.
- R8: With `strobe_or_i`=1, `rd_no` = NOT(`rw_i` AND `phi2_i`) OR `io_sel_no`, and `wr_no` = NOT(NOT `rw_i` AND `phi2_i`) OR `io_sel_no`. In this mode `board_id_i` has no effect on either strobe.
- R9: `rd_no` and `wr_no` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Bus address |
| pers_i | input | 2 | Machine personality, which places the I/O window |
| phi2_i | input | 1 | Phi2 bus clock phase; transfers happen while it is high |
| rw_i | input | 1 | Direction: 1 = read, 0 = write |
| board_id_i | input | 7 | Jumper board number, compared with addr bits 10..4 |
| strobe_or_i | input | 1 | 1 = strobes ORed with the shared select |
| io_sel_no | output | 1 | Shared active-low I/O window select |
| board_cs_no | output | 1 | Active-low board select |
| reg_idx_o | output | 4 | Register index within the 16-byte block |
| rd_no | output | 1 | Active-low read strobe |
| wr_no | output | 1 | Active-low write strobe |

## Verification
Each output is a pure function of the current inputs, so every result is due in the same time step as the stimulus that caused it, with zero cycles of latency. The bench changes all inputs together on the falling edge of its pacing clock. It samples the outputs 1 ns later, which is well before the next rising edge, and compares them with values that bench functions compute from the requirement formulas. Directed cases probe the first and last byte of each window, the bytes just outside each window, board-number hits and near-misses, and both strobe modes with Phi2 low and high.

// File: rtl/io_sel_pkg.sv
package io_sel_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned WIN_W  = 11;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned PERS_W = 2;
  localparam int unsigned BLK_W  = ADDR_W - WIN_W;
  localparam int unsigned ID_W   = WIN_W - IDX_W;
  localparam int unsigned N_PERS = 1 << PERS_W;

  typedef logic [BLK_W-1:0] blk_t;

  // 2 KB block number of the I/O window for each personality code
  function automatic blk_t pers_block(input int unsigned code);
    case (code)
      0:       return blk_t'(5'h1D);
      1:       return blk_t'(5'h12);
      2:       return blk_t'(5'h18);
      default: return blk_t'(5'h1B);
    endcase
  endfunction
endpackage

// File: rtl/io_window_decode.sv
module io_window_decode
  import io_sel_pkg::*;
(
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [PERS_W-1:0] pers_i,
  output logic              io_sel_no
);
  logic [N_PERS-1:0] hit;

  for (genvar g = 0; g < N_PERS; g++) begin : g_pers
    assign hit[g] = (blk_i == pers_block(g));
  end

  assign io_sel_no = ~hit[pers_i];
endmodule

// File: rtl/io_board_match.sv
module io_board_match
  import io_sel_pkg::*;
(
  input  logic            io_sel_ni,
  input  logic [ID_W-1:0] addr_id_i,
  input  logic [ID_W-1:0] board_id_i,
  output logic            board_cs_no
);
  assign board_cs_no = io_sel_ni | (addr_id_i != board_id_i);
endmodule

// File: rtl/io_strobe_gen.sv
module io_strobe_gen (
  input  logic phi2_i,
  input  logic rw_i,
  input  logic strobe_or_i,
  input  logic io_sel_ni,
  input  logic board_cs_ni,
  output logic rd_no,
  output logic wr_no
);
  logic rd_bus_n, wr_bus_n, gate_n;

  // bus-style strobes, carrying timing and direction only
  assign rd_bus_n = ~(phi2_i & rw_i);
  assign wr_bus_n = ~(phi2_i & ~rw_i);

  // OR mode folds in the shared select; normal mode uses the board match
  assign gate_n = strobe_or_i ? io_sel_ni : board_cs_ni;

  assign rd_no = rd_bus_n | gate_n;
  assign wr_no = wr_bus_n | gate_n;
endmodule

// File: rtl/io_sel_top.sv
module io_sel_top
  import io_sel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PERS_W-1:0] pers_i,
  input  logic              phi2_i,
  input  logic              rw_i,
  input  logic [ID_W-1:0]   board_id_i,
  input  logic              strobe_or_i,
  output logic              io_sel_no,
  output logic              board_cs_no,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              rd_no,
  output logic              wr_no
);
  logic sel_n, cs_n;

  io_window_decode u_win (
    .blk_i     (addr_i[ADDR_W-1:WIN_W]),
    .pers_i    (pers_i),
    .io_sel_no (sel_n)
  );

  io_board_match u_match (
    .io_sel_ni   (sel_n),
    .addr_id_i   (addr_i[WIN_W-1:IDX_W]),
    .board_id_i  (board_id_i),
    .board_cs_no (cs_n)
  );

  io_strobe_gen u_strb (
    .phi2_i      (phi2_i),
    .rw_i        (rw_i),
    .strobe_or_i (strobe_or_i),
    .io_sel_ni   (sel_n),
    .board_cs_ni (cs_n),
    .rd_no       (rd_no),
    .wr_no       (wr_no)
  );

  assign io_sel_no   = sel_n;
  assign board_cs_no = cs_n;
  assign reg_idx_o   = addr_i[IDX_W-1:0];
endmodule

// File: rtl/io_sel_checker.sv
module io_sel_checker (
  input logic phi2_i,
  input logic rw_i,
  input logic strobe_or_i,
  input logic io_sel_no,
  input logic board_cs_no,
  input logic rd_no,
  input logic wr_no
);
  always_comb begin
    if (!board_cs_no) AST_CS_NEEDS_SEL: assert (!io_sel_no);                 // R3
    if (!strobe_or_i && !rd_no) AST_RD_NEEDS_CS: assert (!board_cs_no && rw_i); // R5
    if (!strobe_or_i && !wr_no) AST_WR_NEEDS_CS: assert (!board_cs_no && !rw_i); // R6
    if (!phi2_i) AST_NO_STROBE_PHI2_LOW: assert (rd_no && wr_no);            // R7
    if (!rd_no || !wr_no) AST_STROBE_NEEDS_SEL: assert (!io_sel_no);         // R8
    AST_ONE_STROBE: assert (rd_no || wr_no);                                 // R9
  end
endmodule

bind io_sel_top io_sel_checker u_chk (
  .phi2_i      (phi2_i),
  .rw_i        (rw_i),
  .strobe_or_i (strobe_or_i),
  .io_sel_no   (io_sel_no),
  .board_cs_no (board_cs_no),
  .rd_no       (rd_no),
  .wr_no       (wr_no)
);

// File: tb/tb_io_sel_top.sv
`timescale 1ns/1ps
module tb_io_sel_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] addr;
  logic [1:0]  pers;
  logic        phi2, rw, smode;
  logic [6:0]  bid;
  logic        sel_n, cs_n, rd_n, wr_n;
  logic [3:0]  idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  io_sel_top dut (
    .addr_i(addr), .pers_i(pers), .phi2_i(phi2), .rw_i(rw),
    .board_id_i(bid), .strobe_or_i(smode),
    .io_sel_no(sel_n), .board_cs_no(cs_n), .reg_idx_o(idx),
    .rd_no(rd_n), .wr_no(wr_n)
  );

  function automatic logic [4:0] blk_of(input logic [1:0] p);
    case (p)
      2'd0: return 5'h1D;
      2'd1: return 5'h12;
      2'd2: return 5'h18;
      default: return 5'h1B;
    endcase
  endfunction

  function automatic logic e_sel(input logic [15:0] a, input logic [1:0] p);
    return !(a[15:11] == blk_of(p));
  endfunction

  function automatic logic e_cs(input logic [15:0] a, input logic [1:0] p, input logic [6:0] b);
    return !(!e_sel(a, p) && a[10:4] == b);
  endfunction

  function automatic logic e_rd(input logic [15:0] a, input logic [1:0] p, input logic [6:0] b,
                                input logic ph, input logic r, input logic m);
    if (m) return !(r && ph) || e_sel(a, p);
    return !(!e_cs(a, p, b) && r && ph);
  endfunction

  function automatic logic e_wr(input logic [15:0] a, input logic [1:0] p, input logic [6:0] b,
                                input logic ph, input logic r, input logic m);
    if (m) return !(!r && ph) || e_sel(a, p);
    return !(!e_cs(a, p, b) && !r && ph);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h pers=%0d bid=%h phi2=%b rw=%b mode=%b act=%h exp=%h",
               req, addr, pers, bid, phi2, rw, smode, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns later (combinational, zero latency)
  task automatic apply(input logic [15:0] a, input logic [1:0] p, input logic [6:0] b,
                       input logic ph, input logic r, input logic m);
    @(negedge clk);
    addr = a; pers = p; bid = b; phi2 = ph; rw = r; smode = m;
    #1;
    chk("R1/R2 io_sel", {15'd0, sel_n}, {15'd0, e_sel(a, p)});
    chk("R3 board_cs", {15'd0, cs_n}, {15'd0, e_cs(a, p, b)});
    chk("R4 reg_idx", {12'd0, idx}, {12'd0, a[3:0]});
    chk(m ? "R8 rd_or" : "R5 rd", {15'd0, rd_n}, {15'd0, e_rd(a, p, b, ph, r, m)});
    chk(m ? "R8 wr_or" : "R6 wr", {15'd0, wr_n}, {15'd0, e_wr(a, p, b, ph, r, m)});
    if (!ph) chk("R7 phi2 low", {14'd0, rd_n, wr_n}, 16'd3);
    chk("R9 one strobe", {15'd0, rd_n | wr_n}, 16'd1);
  endtask

  initial begin
    addr = '0; pers = '0; bid = '0; phi2 = 0; rw = 1; smode = 0;
    void'($urandom(32'h5EED_1234));
    // idle state: phi2 low, no strobe
    #1;
    chk("R7 initial strobes", {14'd0, rd_n, wr_n}, 16'd3);
    // window edges per personality
    for (int p = 0; p < 4; p++) begin
      logic [15:0] base;
      base = {blk_of(2'(p)), 11'd0};
      apply(base - 16'd1, 2'(p), 7'h00, 1, 1, 0);
      apply(base, 2'(p), 7'h00, 1, 1, 0);
      apply(base + 16'h07FF, 2'(p), 7'h7F, 1, 0, 0);
      apply(base + 16'h0800, 2'(p), 7'h00, 1, 0, 0);
    end
    // personality 0 at $E800, board 0x05 -> $E850..$E85F
    apply(16'hE853, 2'd0, 7'h05, 1, 1, 0); // R5 read hit
    apply(16'hE853, 2'd0, 7'h05, 1, 0, 0); // R6 write hit
    apply(16'hE863, 2'd0, 7'h05, 1, 0, 0); // R3 near miss
    apply(16'hE853, 2'd0, 7'h05, 0, 0, 0); // R7 phi2 low
    apply(16'hE853, 2'd1, 7'h05, 1, 1, 0); // R1 other personality
    // R8: OR mode ignores board number
    apply(16'hE863, 2'd0, 7'h05, 1, 1, 1);
    apply(16'hE863, 2'd0, 7'h05, 1, 0, 1);
    apply(16'hE863, 2'd0, 7'h05, 0, 0, 1);
    apply(16'h1234, 2'd0, 7'h23, 1, 0, 1);
    // R2: change of phi2/rw leaves select alone
    apply(16'hD805, 2'd3, 7'h00, 0, 1, 0);
    apply(16'hD805, 2'd3, 7'h00, 1, 0, 0);
    // random, biased into windows
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  p;
      logic [15:0] a;
      logic [6:0]  b;
      p = 2'($urandom_range(0, 3));
      a = 16'($urandom);
      if ($urandom_range(0, 1) == 1) a[15:11] = blk_of(p);
      b = 7'($urandom);
      if ($urandom_range(0, 2) == 0) b = a[10:4];
      apply(a, p, b, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule